// File: doc/BRIEF.md
# Read-clear interrupt flag controller

This block gathers three single-cycle event pulses (alarm, periodic and update-ended) into sticky status flags and drives one active-low interrupt request line. A flag is set whenever its event arrives. The request line only asserts for sources whose enable bit is also set, so software can poll the flags with interrupts off or run fully interrupt-driven.

Software writes the three enable bits through a one-cycle write strobe. It reads the status through a level read strobe. The status is captured when the strobe first rises and is held unchanged until the strobe drops. On the clock edge that first sees the strobe low, every flag and the summary bit are cleared. Events that arrived while the strobe was high are kept in a pending store and set into the flags on that same clearing edge. An event pulse on that clearing edge is also set. No event is lost across a read.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags and enables are 0, `irq_n_o` is 1 and `stat_rdata_o` is 0.
- R2: An event pulse outside a read sets its flag whatever the enable bits hold. Flag and enable positions are bit 6 periodic, bit 5 alarm and bit 4 update-ended, in both `stat_rdata_o` and `cfg_wdata_i`.
- R3: `irq_n_o` is 0 exactly when at least one source has both its flag and its enable bit set. The enables are loaded from `cfg_wdata_i[6:4]` on an edge where `cfg_we_i` is 1.
- R4: If a flag is already set when its enable bit is written to 1, `irq_n_o` goes low in the cycle after the write edge.
- R5: During a read, `stat_rdata_o[7]` is 1 exactly when `irq_n_o` was low at the capture edge, and bits 3..0 are 0.
- R6: `stat_rdata_o` is captured on the first edge that sees `stat_rd_i` high. It stays stable for as long as `stat_rd_i` remains high.
- R7: On the first edge that sees `stat_rd_i` low after a read, all flags clear, so the summary reads 0 and `irq_n_o` returns high unless deferred events refill flags.
- R8: An event during a read, including one on the capture edge, is absent from that read's data. It is set into its flag on the clearing edge.
- R9: An event pulse on the clearing edge itself sets its flag.
- R10: Any combination of the three flags can be returned set in one read. Outside a read `stat_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_alarm_i | input | 1 | Alarm event pulse |
| evt_periodic_i | input | 1 | Periodic event pulse |
| evt_update_i | input | 1 | Update-ended event pulse |
| cfg_we_i | input | 1 | Enable-register write strobe |
| cfg_wdata_i | input | 8 | Write data; enables in bits 6/5/4 |
| stat_rd_i | input | 1 | Status read strobe, held high for the read |
| stat_rdata_o | output | 8 | Captured status during a read, else 0 |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled on the clock, that a read strobe stays high for at least one edge, and that enables are written only with the strobe low. The sweep drives every combination of event mask and enable mask between reads that are separated by idle cycles. The deferred-event and clearing-edge cases are driven as separate, isolated sequences, so that the pending store always starts empty.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    // Per-source storage: visible flag plus an event held back during a read
    typedef struct packed {
        logic flag;
        logic pend;
    } lane_state_t;

    // Read sequencer state: a read window is open
    typedef struct packed {
        logic busy;
    } seq_state_t;

endpackage

// File: rtl/irq_flag_lane.sv
module irq_flag_lane
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic defer_i,
    input  logic post_i,
    output logic flag_o,
    output logic pend_o
);

    lane_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (post_i) begin
            // clearing edge: drop old flag, post deferred and coincident events
            state_d.flag = state_q.pend | evt_i;
            state_d.pend = 1'b0;
        end else if (defer_i) begin
            state_d.pend = state_q.pend | evt_i;
        end else begin
            state_d.flag = state_q.flag | evt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o = state_q.flag;
    assign pend_o = state_q.pend;

endmodule

// File: rtl/irq_rd_seq.sv
module irq_rd_seq
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    output logic capture_o,
    output logic defer_o,
    output logic post_o,
    output logic busy_o
);

    seq_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.busy = rd_i;
        capture_o    = rd_i & ~state_q.busy;
        defer_o      = rd_i;
        post_o       = state_q.busy & ~rd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o = state_q.busy;

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
    parameter int DATA_W    = 8,
    parameter int NUM_SRC   = 3,
    parameter int FIELD_LSB = 4,
    parameter int SUM_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_alarm_i,
    input  logic              evt_periodic_i,
    input  logic              evt_update_i,
    input  logic              cfg_we_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              stat_rd_i,
    output logic [DATA_W-1:0] stat_rdata_o,
    output logic              irq_n_o
);

    localparam int FIELD_MSB = FIELD_LSB + NUM_SRC - 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [DATA_W-1:0]  snap;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] flag_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic               rd_capture;
    logic               rd_defer;
    logic               rd_post;
    logic               rd_busy;
    logic               irq_act;

    // index 0 update-ended (bit 4), 1 alarm (bit 5), 2 periodic (bit 6)
    assign evt_vec = NUM_SRC'({evt_periodic_i, evt_alarm_i, evt_update_i});

    irq_rd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (stat_rd_i),
        .capture_o (rd_capture),
        .defer_o   (rd_defer),
        .post_o    (rd_post),
        .busy_o    (rd_busy)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lane
        irq_flag_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_vec[g]),
            .defer_i (rd_defer),
            .post_i  (rd_post),
            .flag_o  (flag_vec[g]),
            .pend_o  (pend_vec[g])
        );
    end

    assign irq_act = |(flag_vec & state_q.en);

    always_comb begin
        state_d = state_q;
        if (cfg_we_i) begin
            state_d.en = cfg_wdata_i[FIELD_MSB:FIELD_LSB];
        end
        if (rd_capture) begin
            state_d.snap                        = '0;
            state_d.snap[SUM_BIT]               = irq_act;
            state_d.snap[FIELD_MSB:FIELD_LSB]   = flag_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_rdata_o = rd_busy ? state_q.snap : '0;
    assign irq_n_o      = ~irq_act;

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int DATA_W  = 8,
    parameter int NUM_SRC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SRC-1:0] evt,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] pend,
    input logic              busy,
    input logic              rd,
    input logic              we,
    input logic [NUM_SRC-1:0] wen,
    input logic [DATA_W-1:0] rdata,
    input logic              irq_n
);

    AST_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !busy) |=> ((flags & $past(evt)) == $past(evt))); // R2

    AST_EN_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !rd && !busy && ((wen & flags) != '0)) |=> !irq_n); // R4

    AST_SUMMARY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !busy) |=> (rdata[DATA_W-1] == !$past(irq_n))); // R5

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[3:0] == 4'h0); // R5

    AST_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd) |=> $stable(rdata)); // R6

    AST_CLEAR_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd) |=> ((flags & ~$past(pend | evt)) == '0)); // R7

    AST_NO_LOSS_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd) |=> ((flags & $past(pend | evt)) == $past(pend | evt))); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rdata == '0)); // R10

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt_vec),
    .flags (flag_vec),
    .pend  (pend_vec),
    .busy  (rd_busy),
    .rd    (stat_rd_i),
    .we    (cfg_we_i),
    .wen   (cfg_wdata_i[FIELD_MSB:FIELD_LSB]),
    .rdata (stat_rdata_o),
    .irq_n (irq_n_o)
);

// File: tb/test_irq_flag_ctrl.sv
module test_irq_flag_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_alarm = 1'b0, evt_periodic = 1'b0, evt_update = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       irq_n;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk; // 50 MHz

    irq_flag_ctrl i_irq_flag_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_alarm_i    (evt_alarm),
        .evt_periodic_i (evt_periodic),
        .evt_update_i   (evt_update),
        .cfg_we_i       (cfg_we),
        .cfg_wdata_i    (cfg_wdata),
        .stat_rd_i      (stat_rd),
        .stat_rdata_o   (stat_rdata),
        .irq_n_o        (irq_n)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // mask bit 0 update-ended, bit 1 alarm, bit 2 periodic
    task automatic set_evt(input logic [2:0] m);
        evt_update   = m[0];
        evt_alarm    = m[1];
        evt_periodic = m[2];
    endtask

    task automatic pulse_evt(input logic [2:0] m);
        set_evt(m);
        tick();
        set_evt(3'b000);
    endtask

    task automatic write_en(input logic [2:0] m);
        cfg_we    = 1'b1;
        cfg_wdata = {1'b0, m, 4'h0};
        tick();
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    // one-edge read: returns captured data, leaves strobe low after close edge
    task automatic do_read(output logic [7:0] d);
        stat_rd = 1'b1;
        tick();
        d = stat_rdata;
        stat_rd = 1'b0;
        tick();
    endtask

    initial begin
        logic [7:0] d, d2;
        logic [7:0] expv;
        @(negedge clk);
        chk(irq_n === 1'b1, "R1 irq_n in reset", irq_n, 1);
        tick();
        rst_n = 1'b1;
        tick();
        chk(irq_n === 1'b1, "R1 irq_n after reset", irq_n, 1);
        chk(stat_rdata === 8'h00, "R1 rdata after reset", stat_rdata, 0);
        do_read(d);
        chk(d === 8'h00, "R1 flags zero after reset", d, 0);

        // exhaustive sweep of event mask x enable mask
        for (int ev = 0; ev < 8; ev++) begin
            for (int en = 0; en < 8; en++) begin
                write_en(3'(en));
                pulse_evt(3'(ev));
                chk(irq_n === ((ev & en) == 0), "R3 irq vs flag&enable", irq_n, int'((ev & en) == 0));
                expv = {((ev & en) != 0) ? 1'b1 : 1'b0, 3'(ev), 4'h0};
                stat_rd = 1'b1;
                tick();
                chk(stat_rdata === expv, "R2 R5 R10 read data", stat_rdata, expv);
                tick();
                chk(stat_rdata === expv, "R6 data stable over long read", stat_rdata, expv);
                stat_rd = 1'b0;
                tick();
                chk(irq_n === 1'b1, "R7 irq released after clear", irq_n, 1);
                chk(stat_rdata === 8'h00, "R10 idle data zero", stat_rdata, 0);
                do_read(d);
                chk(d === 8'h00, "R7 flags cleared", d, 0);
            end
        end

        // R4: enable a flag that is already set
        for (int s = 0; s < 3; s++) begin
            write_en(3'b000);
            pulse_evt(3'(1 << s));
            chk(irq_n === 1'b1, "R4 no irq while disabled", irq_n, 1);
            write_en(3'(1 << s));
            chk(irq_n === 1'b0, "R4 irq on late enable", irq_n, 0);
            do_read(d);
            chk(d === {1'b1, 3'(1 << s), 4'h0}, "R4 read after late enable", d, {1'b1, 3'(1 << s), 4'h0});
        end

        // R8: events during a read, including the capture edge
        write_en(3'b111);
        for (int pre = 0; pre < 8; pre++) begin
            for (int mid = 1; mid < 8; mid++) begin
                pulse_evt(3'(pre));
                stat_rd = 1'b1;
                set_evt(3'(mid));
                tick();
                set_evt(3'b000);
                d = stat_rdata;
                expv = {(pre != 0) ? 1'b1 : 1'b0, 3'(pre), 4'h0};
                chk(d === expv, "R8 capture-edge event not in read", d, expv);
                pulse_evt(3'(mid));
                chk(stat_rdata === expv, "R6 R8 data stable with mid events", stat_rdata, expv);
                stat_rd = 1'b0;
                tick();
                chk(irq_n === 1'b0, "R8 deferred events posted", irq_n, 0);
                do_read(d2);
                chk(d2 === {1'b1, 3'(mid), 4'h0}, "R8 deferred flags", d2, {1'b1, 3'(mid), 4'h0});
            end
        end

        // R9: event on the clearing edge
        for (int m = 1; m < 8; m++) begin
            pulse_evt(3'b111);
            stat_rd = 1'b1;
            tick();
            stat_rd = 1'b0;
            set_evt(3'(m));
            tick();
            set_evt(3'b000);
            chk(irq_n === 1'b0, "R9 close-edge event raises irq", irq_n, 0);
            do_read(d);
            chk(d === {1'b1, 3'(m), 4'h0}, "R9 close-edge event kept", d, {1'b1, 3'(m), 4'h0});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule